// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the current in a motor winding by switching the high-side driver on and off. It runs on the internal oscillator clock. While the high side conducts, current rises until the sense comparator trips. The block then turns the high side off for a fixed 96-clock off-time. During the off-time it reports a decay phase to the gate-drive logic. After the off-time the high side turns back on, and a short blanking window masks the comparator so that the switching spike at turn-on is not mistaken for a trip.

The decay select chooses how the off-time is split between fast decay and slow decay, at four fixed fractions. A separate input selects a blanking length of 6 or 12 clocks. When synchronous rectification is enabled, a flag asks the gate drive to close the low-resistance switches during decay. The flag is withdrawn once zero current is detected, so that the load current cannot reverse. The external enable input overrides everything else. A direction-change strobe restarts blanking.

The controller has four states:
- `ST_HOLD`: enable is low and the high side is off.
- `ST_BLANK`: the high side is on and the comparator is masked.
- `ST_RUN`: the high side is on and the comparator is watched.
- `ST_OFF`: the fixed off-time is running.

Transitions, in priority order:
- Enable low, from any state, goes to `ST_HOLD`.
- `ST_HOLD` with enable high goes to `ST_BLANK`.
- `ST_RUN` with a direction strobe goes to `ST_BLANK`. Otherwise `ST_RUN` with a trip goes to `ST_OFF`.
- `ST_OFF` goes to `ST_BLANK` at the end of its 96th clock.
- `ST_BLANK` with a direction strobe restarts `ST_BLANK`. Otherwise `ST_BLANK` goes to `ST_RUN` at the end of the window.

Top module: `off_time_chopper`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on the first cycle after it is released, the outputs read as follows: `src_on_o`=0, `decay_o`=00, `blank_o`=0 and `sync_rect_o`=0. After reset the controller sits in `ST_HOLD`.
- R2: A trip sampled in `ST_RUN` (with enable high and no direction strobe) drops `src_on_o` on the next cycle. `src_on_o` then stays low for exactly 96 clocks.
- R3: `decay_o` encodes the decay phase: 00 means none, 01 means fast and 10 means slow. It reads 00 whenever the source is on. Decay select 00 gives 96 slow cycles. Decay select 11 gives 96 fast cycles.
- R4: Decay select 01 gives 14 fast cycles followed by 82 slow cycles. Decay select 10 gives 46 fast cycles followed by 50 slow cycles. The select is sampled on the trip cycle, and fast cycles never follow slow cycles within one off-time.
- R5: After the off-time, `src_on_o` and `blank_o` are both high for 6 clocks when `blank_long_i`=0, and for 12 clocks when it is 1. The blank select is sampled as blanking starts. `ST_RUN` follows the window.
- R6: Trips that arrive during the off-time or the blanking window have no effect on their length.
- R7: Enable sampled low makes the next cycle show the source off, decay 00, and no blanking. Enable sampled high in `ST_HOLD` starts a blanking window.
- R8: A direction strobe in `ST_RUN` or `ST_BLANK` starts a full new blanking window, and it wins over a trip in the same cycle. A direction strobe during the off-time is ignored.
- R9: `sync_rect_o` is high during the off-time while `sr_en_i` is high and no zero-current pulse has been sampled since that off-time began. One cycle after `zero_i` is sampled high, it goes low for the rest of that off-time.
- R10: With `sr_en_i` low, `sync_rect_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Sense comparator tripped |
| zero_i | input | 1 | Zero-current detected |
| decay_sel_i | input | 2 | Fast-decay fraction select |
| blank_long_i | input | 1 | 0: 6-clock blank, 1: 12-clock blank |
| sr_en_i | input | 1 | Synchronous rectification enable |
| enable_i | input | 1 | External enable / PWM input |
| dir_chg_i | input | 1 | Direction-change strobe |
| src_on_o | output | 1 | High-side driver enable |
| decay_o | output | 2 | Decay phase: 00 none, 01 fast, 10 slow |
| sync_rect_o | output | 1 | Close rectifying switches |
| blank_o | output | 1 | Comparator masked |

## Verification
The bench goes after the following corner cases:
- The fast/slow boundary in both mixed modes. A truncation or off-by-one error would move it to 13, 15, 45 or 47 cycles.
- The exact 96-clock off-time and both blanking lengths. A miscounting terminal compare would stretch or shorten them by one.
- Trips held high through the off-time and the blanking window. A design that re-arms early would restart the off-time.
- Direction strobes inside the off-time and the blanking window. A wrong design would either lengthen the off-time or fail to restart blanking.
- A zero-current pulse in mid-decay. A design that forgets the pulse would keep rectifying into reverse current.

Random traffic is compared cycle by cycle against a reference model built from the requirements.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFF   = 2'd2,
        ST_BLANK = 2'd3
    } chop_state_e;

    localparam logic [1:0] DK_NONE = 2'b00;
    localparam logic [1:0] DK_FAST = 2'b01;
    localparam logic [1:0] DK_SLOW = 2'b10;

endpackage

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
    parameter int OFF_CYC    = 96,
    parameter int MIX_LO_PCT = 15,
    parameter int MIX_HI_PCT = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       start_i,
    input  logic       run_i,
    input  logic [1:0] mode_i,
    output logic       done_o,
    output logic       fast_o
);
    localparam int CW    = $clog2(OFF_CYC + 1);
    localparam int FL_LO = (OFF_CYC * MIX_LO_PCT) / 100;
    localparam int FL_HI = (OFF_CYC * MIX_HI_PCT) / 100;

    logic [CW-1:0] cnt_q;
    logic [1:0]    mode_q;
    logic [CW-1:0] fast_len;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            mode_q <= 2'b00;
        end else if (start_i) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
        end else if (run_i && !done_o) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (mode_q)
            2'b00: fast_len = '0;
            2'b01: fast_len = CW'(FL_LO);
            2'b10: fast_len = CW'(FL_HI);
            2'b11: fast_len = CW'(OFF_CYC);
        endcase
    end

    assign done_o = run_i && (cnt_q == CW'(OFF_CYC - 1));
    assign fast_o = cnt_q < fast_len;

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic start_i,
    input  logic long_i,
    input  logic run_i,
    output logic done_o
);
    localparam int BW = $clog2(BLANK_LONG + 1);

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            last_q <= BW'(BLANK_SHORT - 1);
        end else if (start_i) begin
            cnt_q  <= '0;
            last_q <= long_i ? BW'(BLANK_LONG - 1) : BW'(BLANK_SHORT - 1);
        end else if (run_i && !done_o) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == last_q);

endmodule

// File: rtl/chop_sr_guard.sv
module chop_sr_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic in_off_i,
    input  logic zero_i,
    output logic cut_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || arm_i) begin
            cut_o <= 1'b0;
        end else if (in_off_i && zero_i) begin
            cut_o <= 1'b1;
        end
    end
endmodule

// File: rtl/off_time_chopper.sv
module off_time_chopper #(
    parameter int OFF_CYC     = 96,
    parameter int MIX_LO_PCT  = 15,
    parameter int MIX_HI_PCT  = 48,
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic       zero_i,
    input  logic [1:0] decay_sel_i,
    input  logic       blank_long_i,
    input  logic       sr_en_i,
    input  logic       enable_i,
    input  logic       dir_chg_i,
    output logic       src_on_o,
    output logic [1:0] decay_o,
    output logic       sync_rect_o,
    output logic       blank_o
);
    import chop_pkg::*;

    chop_state_e state_q, state_d;
    logic off_start, blk_start, hold_clr;
    logic off_done, off_fast, blk_done, zero_cut;
    logic in_off, in_blank;

    assign in_off   = (state_q == ST_OFF);
    assign in_blank = (state_q == ST_BLANK);
    assign hold_clr = !enable_i;

    // Next state: enable low overrides everything else.
    always_comb begin
        state_d   = state_q;
        off_start = 1'b0;
        blk_start = 1'b0;
        if (!enable_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    state_d   = ST_BLANK;
                    blk_start = 1'b1;
                end
                ST_RUN: begin
                    if (dir_chg_i) begin
                        state_d   = ST_BLANK;
                        blk_start = 1'b1;
                    end else if (trip_i) begin
                        state_d   = ST_OFF;
                        off_start = 1'b1;
                    end
                end
                ST_OFF: begin
                    if (off_done) begin
                        state_d   = ST_BLANK;
                        blk_start = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (dir_chg_i) begin
                        blk_start = 1'b1;
                    end else if (blk_done) begin
                        state_d = ST_RUN;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs.
    always_comb begin
        src_on_o    = 1'b0;
        blank_o     = 1'b0;
        decay_o     = DK_NONE;
        sync_rect_o = 1'b0;
        unique case (state_q)
            ST_HOLD: ;
            ST_RUN:  src_on_o = 1'b1;
            ST_BLANK: begin
                src_on_o = 1'b1;
                blank_o  = 1'b1;
            end
            ST_OFF: begin
                decay_o     = off_fast ? DK_FAST : DK_SLOW;
                sync_rect_o = sr_en_i && !zero_cut;
            end
        endcase
    end

    chop_off_timer #(
        .OFF_CYC    (OFF_CYC),
        .MIX_LO_PCT (MIX_LO_PCT),
        .MIX_HI_PCT (MIX_HI_PCT)
    ) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (hold_clr),
        .start_i (off_start),
        .run_i   (in_off),
        .mode_i  (decay_sel_i),
        .done_o  (off_done),
        .fast_o  (off_fast)
    );

    chop_blank_timer #(
        .BLANK_SHORT (BLANK_SHORT),
        .BLANK_LONG  (BLANK_LONG)
    ) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (hold_clr),
        .start_i (blk_start),
        .long_i  (blank_long_i),
        .run_i   (in_blank),
        .done_o  (blk_done)
    );

    chop_sr_guard u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (off_start),
        .in_off_i (in_off),
        .zero_i   (zero_i),
        .cut_o    (zero_cut)
    );

endmodule

// File: rtl/chop_checker.sv
module chop_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trip_i,
    input logic       zero_i,
    input logic       sr_en_i,
    input logic       enable_i,
    input logic       dir_chg_i,
    input logic       src_on_o,
    input logic [1:0] decay_o,
    input logic       sync_rect_o,
    input logic       blank_o
);
    a_r2_trip_cuts_source: assert property (@(posedge clk) disable iff (!rst_n)
        (src_on_o && !blank_o && enable_i && !dir_chg_i && trip_i)
        |=> (!src_on_o && decay_o != 2'b00));

    a_r3_no_decay_while_on: assert property (@(posedge clk) disable iff (!rst_n)
        src_on_o |-> (decay_o == 2'b00));

    a_r4_no_fast_after_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_o == 2'b10 && enable_i) |=> (decay_o != 2'b01));

    a_r5_blank_with_source: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> src_on_o);

    a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!src_on_o && decay_o == 2'b00 && !blank_o));

    a_r9_sync_only_decay: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rect_o |-> (!src_on_o && decay_o != 2'b00 && sr_en_i));

    a_r9_zero_cuts_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rect_o && zero_i && enable_i) |=> !sync_rect_o);
endmodule

bind off_time_chopper chop_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (trip_i),
    .zero_i      (zero_i),
    .sr_en_i     (sr_en_i),
    .enable_i    (enable_i),
    .dir_chg_i   (dir_chg_i),
    .src_on_o    (src_on_o),
    .decay_o     (decay_o),
    .sync_rect_o (sync_rect_o),
    .blank_o     (blank_o)
);

// File: tb/tb_off_time_chopper.sv
module tb_off_time_chopper;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_i = 1'b0, zero_i = 1'b0, blank_long_i = 1'b0;
    logic sr_en_i = 1'b0, enable_i = 1'b0, dir_chg_i = 1'b0;
    logic [1:0] decay_sel_i = 2'b00;
    logic src_on_o, sync_rect_o, blank_o;
    logic [1:0] decay_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    off_time_chopper dut (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .zero_i(zero_i),
        .decay_sel_i(decay_sel_i), .blank_long_i(blank_long_i),
        .sr_en_i(sr_en_i), .enable_i(enable_i), .dir_chg_i(dir_chg_i),
        .src_on_o(src_on_o), .decay_o(decay_o),
        .sync_rect_o(sync_rect_o), .blank_o(blank_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Fast-cycle count per decay select, from R3/R4.
    function automatic int fast_cycles(input logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 14;
            2'b10: return 46;
            default: return 96;
        endcase
    endfunction

    // Reference model: 0 hold, 1 run, 2 off, 3 blank.
    int  m_st = 0, m_cnt = 0, m_blen = 6, m_fl = 0;
    bit  m_cut = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cut = 0;
        end else if (!enable_i) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin m_st = 3; m_cnt = 0; m_blen = blank_long_i ? 12 : 6; end
                1: begin
                    if (dir_chg_i) begin m_st = 3; m_cnt = 0; m_blen = blank_long_i ? 12 : 6; end
                    else if (trip_i) begin m_st = 2; m_cnt = 0; m_fl = fast_cycles(decay_sel_i); m_cut = 0; end
                end
                2: begin
                    if (zero_i) m_cut = 1;
                    if (m_cnt == 95) begin m_st = 3; m_cnt = 0; m_blen = blank_long_i ? 12 : 6; end
                    else m_cnt++;
                end
                default: begin
                    if (dir_chg_i) begin m_cnt = 0; m_blen = blank_long_i ? 12 : 6; end
                    else if (m_cnt == m_blen - 1) m_st = 1;
                    else m_cnt++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            int e_dec;
            e_dec = (m_st == 2) ? ((m_cnt < m_fl) ? 1 : 2) : 0;
            if (!rst_n) chk("R1 reset src_on", int'(src_on_o), 0);
            chk("R2 src_on", int'(src_on_o), int'(m_st == 1 || m_st == 3));
            chk("R4 decay", int'(decay_o), e_dec);
            chk("R5 blank", int'(blank_o), int'(m_st == 3));
            chk("R9 sync_rect", int'(sync_rect_o), int'(m_st == 2 && sr_en_i && !m_cut));
        end
    end

    task automatic wait_run();
        trip_i = 0; dir_chg_i = 0; enable_i = 1;
        for (int i = 0; i < 200 && !(src_on_o && !blank_o); i++) @(negedge clk);
    endtask

    // Trip held high throughout (R6); optional direction strobes (R8).
    task automatic measure(input logic [1:0] s, input logic b, input bit dir_off,
                           input bit dir_blk, input string req, input int exp_fast,
                           input int exp_blank);
        int off, fst, blk;
        wait_run();
        trip_i = 1; decay_sel_i = s; blank_long_i = b;
        @(negedge clk);
        off = 0; fst = 0; blk = 0;
        while (!src_on_o && off < 300) begin
            off++;
            if (decay_o == 2'b01) fst++;
            dir_chg_i = (dir_off && off == 10);
            @(negedge clk);
        end
        while (blank_o && blk < 100) begin
            blk++;
            dir_chg_i = (dir_blk && blk == 3);
            @(negedge clk);
        end
        dir_chg_i = 0; trip_i = 0;
        chk({req, " off length R2 R6"}, off, 96);
        chk({req, " fast cycles"}, fst, exp_fast);
        chk({req, " blank length R5"}, blk, exp_blank);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 reset decay", int'(decay_o), 0);
        chk("R1 reset blank", int'(blank_o), 0);
        chk("R1 reset sync", int'(sync_rect_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", int'(src_on_o), 0);

        // Directed off-time splits and blanking lengths.
        measure(2'b00, 1'b0, 0, 0, "R3 sel00", 0, 6);
        measure(2'b11, 1'b1, 0, 0, "R3 sel11", 96, 12);
        measure(2'b01, 1'b0, 0, 0, "R4 sel01", 14, 6);
        measure(2'b10, 1'b1, 0, 0, "R4 sel10", 46, 12);
        measure(2'b01, 1'b0, 1, 1, "R8 dir strobes", 14, 9);

        // R7: enable drop and recovery.
        wait_run();
        enable_i = 0;
        @(negedge clk);
        chk("R7 disabled src_on", int'(src_on_o), 0);
        chk("R7 disabled decay", int'(decay_o), 0);
        enable_i = 1;
        @(negedge clk);
        chk("R7 re-enable blanks", int'(blank_o && src_on_o), 1);

        // R9 / R10: rectification and zero-current cut.
        wait_run();
        sr_en_i = 1; trip_i = 1; decay_sel_i = 2'b00;
        @(negedge clk);
        trip_i = 0;
        repeat (4) @(negedge clk);
        chk("R9 sync during decay", int'(sync_rect_o), 1);
        zero_i = 1;
        @(negedge clk);
        zero_i = 0;
        chk("R9 sync cut after zero", int'(sync_rect_o), 0);
        repeat (10) @(negedge clk);
        chk("R9 sync stays cut", int'(sync_rect_o), 0);
        sr_en_i = 0;
        wait_run();
        trip_i = 1;
        @(negedge clk);
        trip_i = 0;
        repeat (3) @(negedge clk);
        chk("R10 sync off when disabled", int'(sync_rect_o), 0);

        // Constrained random traffic against the model.
        for (int i = 0; i < 20000; i++) begin
            trip_i       = ($urandom_range(0, 3) == 0);
            zero_i       = ($urandom_range(0, 29) == 0);
            dir_chg_i    = ($urandom_range(0, 79) == 0);
            enable_i     = ($urandom_range(0, 59) != 0);
            sr_en_i      = ($urandom_range(0, 3) != 0);
            decay_sel_i  = 2'($urandom_range(0, 3));
            blank_long_i = 1'($urandom_range(0, 1));
            @(negedge clk);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule